// File: doc/BRIEF.md
# EEPROM Byte Address Counter

This block keeps the current byte address of a 16K x 8 serial EEPROM. The protocol engine loads it with the two address bytes of a dummy write, and it then supplies the address for every following current-address or sequential read. After each byte the engine has accessed, the engine asks the counter to step. A read step and a write step follow different wrap rules. A read step runs through the whole array and goes from the top address back to zero. A write step moves only the offset inside the current 64-byte page, so the page number never changes.

The counter is registered. A request seen at one rising clock edge shows on `addr_out` from that edge on. After reset the stored address has no meaning, and `addr_valid` stays low until the first load.

Top module: `eeprom_addr_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `addr_valid` goes to 0 at that edge.
- R2: At an edge where `load_en` is 1, `addr_out` takes `load_addr` and `addr_valid` goes to 1.
- R3: A read step (`rd_step`=1, `wr_step`=0, `load_en`=0) sets `addr_out` to its old value plus one, modulo 16384, so 0x3FFF is followed by 0x0000.
- R4: A write step (`wr_step`=1, `load_en`=0) adds one to bits [5:0] modulo 64 and leaves bits [13:6] unchanged, so 0x12BF is followed by 0x1280.
- R5: `load_en` wins over `rd_step` and `wr_step` in the same cycle, and `addr_out` takes `load_addr`.
- R6: When `rd_step` and `wr_step` are both 1 and `load_en` is 0, the write rule of R4 applies.
- R7: With no request, `addr_out` and `addr_valid` keep their values.
- R8: Steps do not change `addr_valid`. Steps before the first load leave it at 0, and once set it stays at 1 until reset.
- R9: Read steps repeated across the top of the array keep counting: 0x3FFE, 0x3FFF, 0x0000, 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Load `load_addr` into the counter |
| load_addr | input | 14 | Address taken from the dummy write |
| rd_step | input | 1 | A byte was read: step with the whole-array wrap |
| wr_step | input | 1 | A byte was written: step with the in-page wrap |
| addr_out | output | 14 | Current byte address |
| addr_valid | output | 1 | The address has been loaded since reset |

## Verification
The checker tests the following on every cycle:
- loading and load priority;
- the read step as a 14-bit increment;
- the write step as a 6-bit increment with the page bits unchanged;
- holding with no request;
- `addr_valid` rising only after a load and never falling outside reset.

Some behaviour needs known data values, so only the bench's directed scenarios show it: the exact wrap points at 0x3FFF and at a page's last byte, a write step that wins over a read step at the page boundary, and a sequential read running on past the array wrap.

// File: rtl/eeaddr_pkg.sv
package eeaddr_pkg;

    localparam int unsigned ADDR_W_DEF = 14;
    localparam int unsigned PAGE_W_DEF = 6;

    typedef struct packed {
        logic load;
        logic rd;
        logic wr;
    } step_req_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_LOAD = 2'd1,
        STEP_RD   = 2'd2,
        STEP_WR   = 2'd3
    } step_kind_e;

    // Priority: load, then write step, then read step.
    function automatic step_kind_e pick_kind(step_req_t req);
        if (req.load)    return STEP_LOAD;
        else if (req.wr) return STEP_WR;
        else if (req.rd) return STEP_RD;
        else             return STEP_HOLD;
    endfunction

endpackage

// File: rtl/eeaddr_next.sv
module eeaddr_next #(
    parameter int unsigned ADDR_W = eeaddr_pkg::ADDR_W_DEF,
    parameter int unsigned PAGE_W = eeaddr_pkg::PAGE_W_DEF
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] rd_next,
    output logic [ADDR_W-1:0] wr_next
);
    // Read step: the whole array wraps.
    assign rd_next = cur + ADDR_W'(1);

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            assign wr_next = cur + ADDR_W'(1);
        end else begin : g_paged
            logic [PAGE_W-1:0] offs_next;
            assign offs_next = cur[PAGE_W-1:0] + PAGE_W'(1);
            assign wr_next   = {cur[ADDR_W-1:PAGE_W], offs_next};
        end
    endgenerate
endmodule

// File: rtl/eeaddr_state.sv
module eeaddr_state
    import eeaddr_pkg::*;
#(
    parameter int unsigned ADDR_W = eeaddr_pkg::ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  step_kind_e        kind,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ADDR_W-1:0] rd_next,
    input  logic [ADDR_W-1:0] wr_next,
    output logic [ADDR_W-1:0] addr_q,
    output logic              valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            unique case (kind)
                STEP_LOAD: begin
                    addr_q  <= load_addr;
                    valid_q <= 1'b1;
                end
                STEP_RD:   addr_q <= rd_next;
                STEP_WR:   addr_q <= wr_next;
                default:   addr_q <= addr_q;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_addr_counter.sv
module eeprom_addr_counter
    import eeaddr_pkg::*;
#(
    parameter int unsigned ADDR_W = eeaddr_pkg::ADDR_W_DEF,
    parameter int unsigned PAGE_W = eeaddr_pkg::PAGE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              rd_step,
    input  logic              wr_step,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_valid
);
    step_req_t         req;
    step_kind_e        kind;
    logic [ADDR_W-1:0] rd_next;
    logic [ADDR_W-1:0] wr_next;

    assign req  = '{load: load_en, rd: rd_step, wr: wr_step};
    assign kind = pick_kind(req);

    eeaddr_next #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_next (
        .cur     (addr_out),
        .rd_next (rd_next),
        .wr_next (wr_next)
    );

    eeaddr_state #(.ADDR_W(ADDR_W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .load_addr (load_addr),
        .rd_next   (rd_next),
        .wr_next   (wr_next),
        .addr_q    (addr_out),
        .valid_q   (addr_valid)
    );
endmodule

// File: rtl/eeaddr_chk.sv
module eeaddr_chk #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned PAGE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              load_en,
    input logic [ADDR_W-1:0] load_addr,
    input logic              rd_step,
    input logic              wr_step,
    input logic [ADDR_W-1:0] addr_out,
    input logic              addr_valid
);
    // R2 R5
    load_takes_addr_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (addr_out == $past(load_addr)) && addr_valid);

    // R3
    read_step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && rd_step && !wr_step) |=> addr_out == $past(addr_out) + ADDR_W'(1));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !rd_step && !wr_step) |=> $stable(addr_out) && $stable(addr_valid));

    // R8
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> addr_valid);

    // R8
    valid_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_valid) |-> $past(load_en));

    generate
        if (PAGE_W < ADDR_W) begin : g_page_chk
            // R4 R6
            write_step_page_chk: assert property (@(posedge clk) disable iff (rst)
                (!load_en && wr_step) |=>
                    (addr_out[ADDR_W-1:PAGE_W] == $past(addr_out[ADDR_W-1:PAGE_W])) &&
                    (addr_out[PAGE_W-1:0] == $past(addr_out[PAGE_W-1:0]) + PAGE_W'(1)));
        end
    endgenerate
endmodule

bind eeprom_addr_counter eeaddr_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .load_addr  (load_addr),
    .rd_step    (rd_step),
    .wr_step    (wr_step),
    .addr_out   (addr_out),
    .addr_valid (addr_valid)
);

// File: tb/tb_eeprom_addr_counter.sv
`timescale 1ns/1ps
module tb_eeprom_addr_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [13:0] load_addr = '0;
    logic        rd_step = 1'b0;
    logic        wr_step = 1'b0;
    logic [13:0] addr_out;
    logic        addr_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    eeprom_addr_counter dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .rd_step(rd_step), .wr_step(wr_step),
        .addr_out(addr_out), .addr_valid(addr_valid)
    );

    // Inputs are set at a falling edge and last for exactly one rising edge.
    task automatic cyc(input logic ld, input logic [13:0] a, input logic rd, input logic wr);
        load_en = ld; load_addr = a; rd_step = rd; wr_step = wr;
        @(negedge clk);
        load_en = 1'b0; rd_step = 1'b0; wr_step = 1'b0;
    endtask

    task automatic chk_addr(input string req, input logic [13:0] exp);
        n_checks++;
        if (addr_out !== exp) begin
            n_fails++;
            $display("FAIL %s addr_out actual=%h expected=%h", req, addr_out, exp);
        end
    endtask

    task automatic chk_valid(input string req, input logic exp);
        n_checks++;
        if (addr_valid !== exp) begin
            n_fails++;
            $display("FAIL %s addr_valid actual=%b expected=%b", req, addr_valid, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk_valid("R1", 1'b0);
    endtask

    task automatic t_steps_before_load();
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk_valid("R8", 1'b0);
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk_valid("R8", 1'b0);
    endtask

    task automatic t_load_and_hold();
        cyc(1'b1, 14'h1234, 1'b0, 1'b0);
        chk_addr("R2", 14'h1234);
        chk_valid("R2", 1'b1);
        @(negedge clk); @(negedge clk);
        chk_addr("R7", 14'h1234);
        chk_valid("R7", 1'b1);
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk_addr("R3", 14'h1235);
    endtask

    task automatic t_read_wrap();
        cyc(1'b1, 14'h3FFE, 1'b0, 1'b0);
        chk_addr("R2", 14'h3FFE);
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk_addr("R9", 14'h3FFF);
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk_addr("R3", 14'h0000);
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk_addr("R9", 14'h0001);
    endtask

    task automatic t_write_wrap();
        cyc(1'b1, 14'h12BE, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk_addr("R4", 14'h12BF);
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk_addr("R4", 14'h1280);
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk_addr("R3", 14'h1281);
    endtask

    task automatic t_priorities();
        cyc(1'b1, 14'h00BF, 1'b0, 1'b0);
        cyc(1'b1, 14'h0A00, 1'b1, 1'b1);
        chk_addr("R5", 14'h0A00);
        cyc(1'b1, 14'h00BF, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b1);
        chk_addr("R6", 14'h0080);
        chk_valid("R8", 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_steps_before_load();
        t_load_and_hold();
        t_read_wrap();
        t_write_wrap();
        t_priorities();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule